// File: doc/BRIEF.md
# Decode-Stage Next-PC Unit with Delay Slot

This block chooses the next fetch address in a five-stage pipeline whose control transfers are settled in the decode stage. It looks at the instruction now in decode, the address of that instruction, and its two register operands. The operands arrive already bypassed from later stages. From these it decides whether a conditional branch, an absolute jump, a jump-and-link or a register jump redirects fetch.

The instruction that follows a control transfer is already being fetched when decode resolves it. That instruction always completes as the delay slot, so nothing is ever flushed. The unit also drives the return address that jump-and-link writes into register 31. That address is two instructions past the jump, which skips the delay slot.

A stall input freezes the fetch address and suppresses any redirect or link write in that cycle. Decode then presents the same instruction again once the stall clears.

Top module: `dslot_pc_unit`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it, `fetch_pc` equals the parameter `RESET_PC` (default 0).
- R2: When `stall` is low and no transfer is taken, `fetch_pc` advances by 4 at the next rising edge. This also holds for opcodes other than those listed in R4 to R8.
- R3: When `stall` is high, `fetch_pc` keeps its value at the next edge, and `redirect` and `link_we` are both 0 in that cycle.
- R4: Opcode bits [31:26] = 6'b000100 (branch-if-equal) is taken when `opnd_a == opnd_b`. Its target is `dec_pc + 4 + (sign-extended bits [15:0] << 2)`.
- R5: Opcode 6'b000101 (branch-if-not-equal) is taken when `opnd_a != opnd_b`, with the same target rule as R4.
- R6: Opcode 6'b000010 (jump) is always taken. Its target is bits [31:28] of `dec_pc + 4`, followed by bits [25:0] of the instruction, followed by two zero bits.
- R7: Opcode 6'b000011 (jump-and-link) jumps as in R6. In the same cycle it drives `link_we` = 1, `link_addr` = 31 and `link_value` = `dec_pc + 8`. `link_we` is 0 for every other instruction.
- R8: Opcode 6'b000000 with function bits [5:0] = 6'b001000 (register jump) is always taken, and its target is `opnd_a`.
- R9: `redirect` is combinational and is high exactly when a transfer is taken and `stall` is low. The target becomes `fetch_pc` at the next rising edge, one cycle later, and no fetched instruction is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes the fetch address and blocks redirect and link |
| dec_insn | input | 32 | Instruction word in the decode stage |
| dec_pc | input | 32 | Address of the decode-stage instruction |
| opnd_a | input | 32 | First register operand, already bypassed |
| opnd_b | input | 32 | Second register operand, already bypassed |
| fetch_pc | output | 32 | Current fetch address |
| redirect | output | 1 | A control transfer is taken this cycle |
| link_we | output | 1 | Write enable for the return address |
| link_addr | output | 5 | Destination register of the return address (31) |
| link_value | output | 32 | Return address, decode address plus 8 |

## Verification
The assertions assume that `stall`, `dec_insn` and both operands are known (never X) on every clock edge after reset. They also assume that the operands are final by the edge, meaning bypassing has already settled. The bench drives every input at the falling edge from a single task and never leaves a port undriven. Because of this, each combinational decision is stable well before the rising edge where the properties sample it. The stimulus keeps `dec_pc` one word behind the fetch address, as a real pipeline would, and it still reaches negative branch offsets and 32-bit address wrap.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int unsigned XLEN     = 32;
  localparam int unsigned OFF_W    = 16;
  localparam int unsigned IDX_W    = 26;
  localparam int unsigned REGA_W   = 5;
  localparam int unsigned REGION_W = XLEN - IDX_W - 2;

  localparam logic [5:0] OPC_REGOP = 6'b000000;
  localparam logic [5:0] OPC_JMP   = 6'b000010;
  localparam logic [5:0] OPC_JAL   = 6'b000011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_BNE   = 6'b000101;
  localparam logic [5:0] FN_JR     = 6'b001000;

  localparam logic [REGA_W-1:0] LINK_REG = 5'd31;

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [2:0] {
    CK_SEQ,
    CK_BEQ,
    CK_BNE,
    CK_JMP,
    CK_JAL,
    CK_JR
  } ctl_kind_e;

  // Address of the instruction after the one at pc.
  function automatic word_t pc_plus4(input word_t pc);
    return pc + word_t'(4);
  endfunction

  // Return address: skip the jump and its delay slot.
  function automatic word_t pc_plus8(input word_t pc);
    return pc + word_t'(8);
  endfunction

  // PC-relative target, word offset measured from the delay slot.
  function automatic word_t rel_target(input word_t pc, input logic [OFF_W-1:0] off);
    word_t sx;
    sx = {{(XLEN-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
    return pc_plus4(pc) + sx;
  endfunction

  // Region-absolute target: upper bits of the delay-slot address kept.
  function automatic word_t abs_target(input word_t pc, input logic [IDX_W-1:0] idx);
    word_t p4;
    p4 = pc_plus4(pc);
    return {p4[XLEN-1 -: REGION_W], idx, 2'b00};
  endfunction

endpackage

// File: rtl/npc_insn_decoder.sv
module npc_insn_decoder
  import npc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  word_t                insn,
  output ctl_kind_e            kind,
  output logic [OFF_W-1:0]     off,
  output logic [IDX_W-1:0]     idx
);

  logic [5:0] opc;
  logic [5:0] fn;
  logic       is_beq, is_bne, is_jmp, is_jal, is_jr;

  assign opc = insn[XLEN-1 -: 6];
  assign fn  = insn[5:0];
  assign off = insn[OFF_W-1:0];
  assign idx = insn[IDX_W-1:0];

  assign is_beq = (opc == OPC_BEQ);
  assign is_bne = (opc == OPC_BNE);
  assign is_jmp = (opc == OPC_JMP);
  assign is_jal = (opc == OPC_JAL);
  assign is_jr  = (opc == OPC_REGOP) && (fn == FN_JR);

  always_comb begin
    kind = CK_SEQ;
    if (is_beq)      kind = CK_BEQ;
    else if (is_bne) kind = CK_BNE;
    else if (is_jmp) kind = CK_JMP;
    else if (is_jal) kind = CK_JAL;
    else if (is_jr)  kind = CK_JR;
  end

  AST_KIND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_beq, is_bne, is_jmp, is_jal, is_jr})); // R8

  AST_JR_NEEDS_FUNCT: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_JR) |-> (insn[5:0] == FN_JR)); // R8

endmodule

// File: rtl/npc_target_calc.sv
module npc_target_calc
  import npc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_kind_e        kind,
  input  word_t            pc,
  input  word_t            opa,
  input  word_t            opb,
  input  logic [OFF_W-1:0] off,
  input  logic [IDX_W-1:0] idx,
  output logic             take,
  output word_t            target,
  output logic             is_link,
  output word_t            link_val
);

  logic  ops_equal;
  word_t t_rel, t_abs;

  assign ops_equal = (opa == opb);
  assign t_rel     = rel_target(pc, off);
  assign t_abs     = abs_target(pc, idx);
  assign link_val  = pc_plus8(pc);
  assign is_link   = (kind == CK_JAL);

  always_comb begin
    take   = 1'b0;
    target = t_rel;
    unique case (kind)
      CK_BEQ: begin take = ops_equal;  target = t_rel; end
      CK_BNE: begin take = !ops_equal; target = t_rel; end
      CK_JMP,
      CK_JAL: begin take = 1'b1;       target = t_abs; end
      CK_JR:  begin take = 1'b1;       target = opa;   end
      default: begin take = 1'b0;      target = t_rel; end
    endcase
  end

  AST_BEQ_ONLY_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_BEQ && take) |-> (opa == opb)); // R4

  AST_BNE_ONLY_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_BNE && take) |-> (opa != opb)); // R5

  AST_JUMPS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CK_JMP || kind == CK_JAL || kind == CK_JR) |-> take); // R6

endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg
  import npc_pkg::*;
#(
  parameter word_t RESET_PC = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stall,
  input  logic  take,
  input  word_t target,
  output word_t pc
);

  word_t pc_next;

  always_comb begin
    if (stall)     pc_next = pc;
    else if (take) pc_next = target;
    else           pc_next = pc_plus4(pc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= RESET_PC;
    else        pc <= pc_next;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pc)); // R3

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !take) |=> (pc == $past(pc) + word_t'(4))); // R2

  AST_REDIRECT_LAND: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && take) |=> (pc == $past(target))); // R9

endmodule

// File: rtl/dslot_pc_unit.sv
module dslot_pc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stall,
  input  logic [31:0] dec_insn,
  input  logic [31:0] dec_pc,
  input  logic [31:0] opnd_a,
  input  logic [31:0] opnd_b,
  output logic [31:0] fetch_pc,
  output logic        redirect,
  output logic        link_we,
  output logic [4:0]  link_addr,
  output logic [31:0] link_value
);

  ctl_kind_e        kind;
  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] idx;
  logic             take_raw;
  logic             is_link;
  word_t            target;
  logic             take_ok;

  npc_insn_decoder u_dec (
    .clk  (clk),
    .rst_n(rst_n),
    .insn (dec_insn),
    .kind (kind),
    .off  (off),
    .idx  (idx)
  );

  npc_target_calc u_tgt (
    .clk     (clk),
    .rst_n   (rst_n),
    .kind    (kind),
    .pc      (dec_pc),
    .opa     (opnd_a),
    .opb     (opnd_b),
    .off     (off),
    .idx     (idx),
    .take    (take_raw),
    .target  (target),
    .is_link (is_link),
    .link_val(link_value)
  );

  assign take_ok   = take_raw && !stall;
  assign redirect  = take_ok;
  assign link_we   = is_link && !stall;
  assign link_addr = LINK_REG;

  npc_pc_reg #(.RESET_PC(RESET_PC)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .stall (stall),
    .take  (take_raw),
    .target(target),
    .pc    (fetch_pc)
  );

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!redirect && !link_we)); // R3

  AST_LINK_ONLY_JAL: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (dec_insn[31:26] == OPC_JAL)); // R7

endmodule

// File: tb/tb_dslot_pc_unit.sv
module tb_dslot_pc_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall;
  logic [31:0] dec_insn, dec_pc, opnd_a, opnd_b;
  logic [31:0] fetch_pc, link_value;
  logic        redirect, link_we;
  logic [4:0]  link_addr;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  logic [31:0] model_pc;

  always #5 clk = ~clk;

  dslot_pc_unit #(.RESET_PC(32'h0000_0000)) dut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .dec_insn(dec_insn),
    .dec_pc(dec_pc), .opnd_a(opnd_a), .opnd_b(opnd_b), .fetch_pc(fetch_pc),
    .redirect(redirect), .link_we(link_we), .link_addr(link_addr),
    .link_value(link_value)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd1, 5'd2, imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] ix);
    return {op, ix};
  endfunction

  localparam logic [31:0] INSN_JR = {6'd0, 5'd31, 15'd0, 6'b001000};

  // Drive one decode cycle at the falling edge, check the combinational
  // outputs, then check the fetch address after the next rising edge.
  task automatic step(input logic [31:0] insn, input logic [31:0] a,
                      input logic [31:0] b, input bit st, input string req);
    logic [5:0]  op;
    logic [31:0] dpc, tgt, exp_next;
    bit          taken, lwe;
    int          offs;
    op  = insn[31:26];
    dpc = model_pc - 32'd4;
    dec_insn = insn; dec_pc = dpc; opnd_a = a; opnd_b = b; stall = st;
    #1;
    taken = 0; tgt = 32'h0;
    offs  = int'($signed(insn[15:0]));
    case (op)
      6'b000100: begin taken = (a == b); tgt = dpc + 32'd4 + 32'(offs * 4); end
      6'b000101: begin taken = (a != b); tgt = dpc + 32'd4 + 32'(offs * 4); end
      6'b000010, 6'b000011: begin
        taken = 1;
        tgt = ((dpc + 32'd4) & 32'hF000_0000) + (32'(insn[25:0]) * 32'd4);
      end
      6'b000000: if (insn[5:0] == 6'b001000) begin taken = 1; tgt = a; end
      default: taken = 0;
    endcase
    if (st) taken = 0;
    lwe = (op == 6'b000011) && !st;
    chk(redirect == taken, st ? "R3" : "R9", {req, " redirect"}, 32'(redirect), 32'(taken));
    chk(link_we == lwe, st ? "R3" : "R7", {req, " link_we"}, 32'(link_we), 32'(lwe));
    if (lwe) begin
      chk(link_value == dpc + 32'd8, "R7", "link_value", link_value, dpc + 32'd8);
      chk(link_addr == 5'd31, "R7", "link_addr", 32'(link_addr), 32'd31);
    end
    exp_next = st ? model_pc : (taken ? tgt : model_pc + 32'd4);
    @(posedge clk);
    #1;
    chk(fetch_pc == exp_next, req, "fetch_pc", fetch_pc, exp_next);
    model_pc = exp_next;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; stall = 1'b0; dec_insn = 32'h0; dec_pc = 32'h0;
    opnd_a = 32'h0; opnd_b = 32'h0;
    repeat (3) @(posedge clk);
    #1;
    chk(fetch_pc == 32'h0, "R1", "reset value", fetch_pc, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    model_pc = 32'h0;

    step(32'h0000_0000, 32'h1, 32'h2, 0, "R2");
    step(32'h0128_4020, 32'h1, 32'h2, 0, "R2");
    step(enc_i(6'b000110, 16'h0010), 32'h5, 32'h5, 0, "R2");
    step(enc_i(6'b000100, 16'h0020), 32'h7, 32'h7, 0, "R4");
    step(enc_i(6'b000100, 16'hFFF0), 32'h9, 32'h9, 0, "R4");
    step(enc_i(6'b000100, 16'h0020), 32'h7, 32'h8, 0, "R4");
    step(enc_i(6'b000101, 16'h0008), 32'h3, 32'h4, 0, "R5");
    step(enc_i(6'b000101, 16'h0008), 32'h4, 32'h4, 0, "R5");
    step(enc_j(6'b000010, 26'h0000_040), 32'h0, 32'h0, 0, "R6");
    step(enc_j(6'b000011, 26'h3FF_FFFF), 32'h0, 32'h0, 0, "R7");
    step(INSN_JR, 32'h0000_1000, 32'h0, 0, "R8");
    step(INSN_JR, 32'hFFFF_FFFC, 32'h0, 0, "R8");
    step(32'h0000_0000, 32'h0, 32'h0, 0, "R2");
    step(enc_j(6'b000011, 26'h0000_100), 32'h0, 32'h0, 1, "R3");
    step(enc_i(6'b000100, 16'h0004), 32'h1, 32'h1, 1, "R3");
    step(32'h0000_0000, 32'h0, 32'h0, 1, "R3");
    step(enc_i(6'b000100, 16'h0004), 32'h1, 32'h1, 0, "R9");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] insn, a, b;
      bit          st;
      int          k;
      k = $urandom_range(0, 6);
      a = $urandom();
      b = ($urandom_range(0, 1) == 1) ? a : $urandom();
      st = ($urandom_range(0, 7) == 0);
      case (k)
        0: insn = enc_i(6'b000100, 16'($urandom()));
        1: insn = enc_i(6'b000101, 16'($urandom()));
        2: insn = enc_j(6'b000010, 26'($urandom()));
        3: insn = enc_j(6'b000011, 26'($urandom()));
        4: insn = INSN_JR;
        5: insn = {6'b000000, 20'($urandom()), 6'b100000};
        default: insn = {6'b001000, 26'($urandom())};
      endcase
      step(insn, a, b, st, "R9");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule